// File: doc/BRIEF.md
# Character LCD Nibble Writer

This block sends one byte at a time to a character display controller wired in four-bit mode. A client offers a byte together with a register-select flag on a valid/ready handshake. Once the block takes the byte, it puts the high half of the byte on the four data pins, pulses the enable strobe, then puts the low half on the pins and pulses the strobe again. Each strobe is framed by a setup window before it and a hold window after it.

Two further waits are enforced. There is a short gap between the two strobes of a byte. After the second strobe there is a long settling interval, so the controller can finish executing the command. The handshake stays closed from the moment a byte is taken until that settling interval ends. The read/write pin is held at the write level at all times. All windows are counted in clock cycles through parameters whose defaults suit a 50 MHz clock: 2 cycles of setup, 12 cycles of strobe, 1 cycle of hold, 50 cycles of gap between nibbles and 2000 cycles of settling.

Top module: `charlcd_nibble_writer`

## Requirements
- R1: After synchronous reset, lcd_strobe, lcd_regsel and lcd_nib are all 0 and in_ready is 1.
- R2: A byte and its register-select flag are captured on a rising edge where in_valid and in_ready are both 1. in_ready is 0 from the next cycle until the settling interval ends.
- R3: lcd_rdwr is 0 in every cycle. The value 0 means write.
- R4: Each byte produces exactly two strobes. lcd_nib carries data[7:4] during the first strobe and data[3:0] during the second. lcd_nib[3] is the most significant data line.
- R5: lcd_regsel equals the captured flag during both strobes of the byte.
- R6: lcd_nib and lcd_regsel are unchanged for at least SETUP_CYC (2) cycles before lcd_strobe rises.
- R7: lcd_strobe stays high for exactly PULSE_CYC (12) cycles per strobe.
- R8: lcd_nib and lcd_regsel keep their strobe values in the first cycle after lcd_strobe falls.
- R9: lcd_strobe is low for at least GAP_CYC (50) cycles between the two strobes of a byte.
- R10: lcd_strobe is low for at least SETTLE_CYC (2000) cycles between the second strobe of a byte and the first strobe of the next byte.
- R11: in_valid and in_data are ignored while in_ready is 0. No extra strobes are produced, and the byte in flight is not altered.
- R12: When in_valid is held at 1, consecutive acceptances are exactly 2*SETUP_CYC + 2*PULSE_CYC + 2*HOLD_CYC + GAP_CYC + SETTLE_CYC + 1 cycles apart. With the defaults this is 2081 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Byte to write |
| in_regsel | input | 1 | Register-select flag for the byte (0 = command, 1 = data) |
| lcd_strobe | output | 1 | Enable strobe to the display |
| lcd_regsel | output | 1 | Register-select line to the display |
| lcd_rdwr | output | 1 | Read/write line, held at 0 (write) |
| lcd_nib | output | 4 | Upper four data lines of the display, bit 3 most significant |

## Verification
The end of the settling interval and the acceptance of the next byte can land in the same cycle. This happens when the client keeps in_valid high. The bench provokes it by streaming bytes back to back. It then judges the exact acceptance period, and checks that the first strobe of the new byte still sees a full settling gap and a full setup window. A second pairing is a stray offer during the busy window while a byte is in flight. The bench drives changing data with in_valid high for hundreds of busy cycles. The scoreboard then confirms that only the accepted byte appears on the pins, intact.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETUP_HI,
        PH_PULSE_HI,
        PH_HOLD_HI,
        PH_GAP,
        PH_SETUP_LO,
        PH_PULSE_LO,
        PH_HOLD_LO,
        PH_SETTLE
    } phase_e;

    typedef struct packed {
        logic [7:0] data;
        logic       regsel;
    } byte_req_t;

    typedef struct packed {
        logic       strobe;
        logic       regsel;
        logic [3:0] nib;
    } pin_bus_t;

    function automatic int unsigned max_of5(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d,
                                            int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

    function automatic phase_e next_phase(phase_e ph);
        case (ph)
            PH_SETUP_HI: return PH_PULSE_HI;
            PH_PULSE_HI: return PH_HOLD_HI;
            PH_HOLD_HI:  return PH_GAP;
            PH_GAP:      return PH_SETUP_LO;
            PH_SETUP_LO: return PH_PULSE_LO;
            PH_PULSE_LO: return PH_HOLD_LO;
            PH_HOLD_LO:  return PH_SETTLE;
            default:     return PH_IDLE;
        endcase
    endfunction

    function automatic int unsigned phase_len(phase_e ph,
                                              int unsigned su, int unsigned pu,
                                              int unsigned ho, int unsigned ga,
                                              int unsigned se);
        case (ph)
            PH_SETUP_HI, PH_SETUP_LO: return su;
            PH_PULSE_HI, PH_PULSE_LO: return pu;
            PH_HOLD_HI, PH_HOLD_LO:   return ho;
            PH_GAP:                   return ga;
            PH_SETTLE:                return se;
            default:                  return 1;
        endcase
    endfunction

    function automatic logic is_upper_phase(phase_e ph);
        return (ph == PH_SETUP_HI) || (ph == PH_PULSE_HI) || (ph == PH_HOLD_HI);
    endfunction

    function automatic pin_bus_t decode_pins(phase_e ph, byte_req_t r);
        pin_bus_t p;
        p.strobe = (ph == PH_PULSE_HI) || (ph == PH_PULSE_LO);
        p.regsel = r.regsel;
        p.nib    = is_upper_phase(ph) ? r.data[7:4] : r.data[3:0];
        return p;
    endfunction

endpackage

// File: rtl/charlcd_timer.sv
module charlcd_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/charlcd_sequencer.sv
module charlcd_sequencer
    import charlcd_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned PULSE_CYC  = 12,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned GAP_CYC    = 50,
    parameter int unsigned SETTLE_CYC = 2000,
    parameter int          CNT_W      = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             expired,
    output phase_e           phase,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        load    = 1'b0;
        if (phase_q == PH_IDLE) begin
            if (accept) begin
                phase_d = PH_SETUP_HI;
                load    = 1'b1;
            end
        end else if (expired) begin
            phase_d = next_phase(phase_q);
            load    = (phase_d != PH_IDLE);
        end
        load_val = CNT_W'(phase_len(phase_d, SETUP_CYC, PULSE_CYC, HOLD_CYC,
                                    GAP_CYC, SETTLE_CYC) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R2: no byte starts without an acceptance
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !accept) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/charlcd_pin_stage.sv
module charlcd_pin_stage
    import charlcd_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_bus_t pins_d,
    output pin_bus_t pins_q
);
    localparam int STAB_W = $clog2(SETUP_CYC + 2);
    localparam logic [STAB_W-1:0] STAB_MAX = STAB_W'(SETUP_CYC);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= '0;
        else     pins_q <= pins_d;
    end

    // cycles the data lines have already held their present value
    logic [STAB_W-1:0] stab_q;
    logic              lines_change;

    assign lines_change = (pins_d.nib != pins_q.nib) || (pins_d.regsel != pins_q.regsel);

    always_ff @(posedge clk) begin
        if (rst)                    stab_q <= '0;
        else if (lines_change)      stab_q <= '0;
        else if (stab_q != STAB_MAX) stab_q <= stab_q + 1'b1;
    end

    assert_setup_window_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.strobe) |-> (stab_q >= STAB_MAX));

    assert_hold_window_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.strobe) |-> ($stable(pins_q.nib) && $stable(pins_q.regsel)));
endmodule

// File: rtl/charlcd_nibble_writer.sv
module charlcd_nibble_writer
    import charlcd_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = 2,
    parameter int unsigned PULSE_CYC  = 12,
    parameter int unsigned HOLD_CYC   = 1,
    parameter int unsigned GAP_CYC    = 50,
    parameter int unsigned SETTLE_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_regsel,
    output logic       lcd_strobe,
    output logic       lcd_regsel,
    output logic       lcd_rdwr,
    output logic [3:0] lcd_nib
);
    localparam int unsigned LONGEST =
        max_of5(SETUP_CYC, PULSE_CYC, HOLD_CYC, GAP_CYC, SETTLE_CYC);
    localparam int CNT_W = $clog2(LONGEST + 1);

    phase_e           phase;
    logic             accept, load, expired;
    logic [CNT_W-1:0] load_val;
    byte_req_t        req_q;
    pin_bus_t         pins_d, pins_q;

    assign in_ready = (phase == PH_IDLE);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (accept) req_q <= '{data: in_data, regsel: in_regsel};
    end

    charlcd_sequencer #(
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
        .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .expired(expired),
        .phase(phase), .load(load), .load_val(load_val)
    );

    charlcd_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
    );

    assign pins_d = decode_pins(phase, req_q);

    charlcd_pin_stage #(.SETUP_CYC(SETUP_CYC)) u_pins (
        .clk(clk), .rst(rst), .pins_d(pins_d), .pins_q(pins_q)
    );

    assign lcd_strobe = pins_q.strobe;
    assign lcd_regsel = pins_q.regsel;
    assign lcd_nib    = pins_q.nib;
    assign lcd_rdwr   = 1'b0;

    // ---- window counters observed at the pins ----
    localparam int HI_W = $clog2(PULSE_CYC + 2);
    localparam logic [HI_W-1:0] HI_MAX = HI_W'(PULSE_CYC + 1);
    localparam int LO_W = $clog2(max_of5(GAP_CYC, SETTLE_CYC, 1, 1, 1) + 1);
    localparam logic [LO_W-1:0] LO_MAX = LO_W'(max_of5(GAP_CYC, SETTLE_CYC, 1, 1, 1));
    localparam logic [LO_W-1:0] GAP_L  = LO_W'(GAP_CYC);
    localparam logic [LO_W-1:0] SET_L  = LO_W'(SETTLE_CYC);
    localparam logic [HI_W-1:0] PUL_L  = HI_W'(PULSE_CYC);

    logic [HI_W-1:0] hi_cnt;
    logic [LO_W-1:0] lo_cnt;
    logic            fall_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            fall_seen <= 1'b0;
        end else begin
            if (lcd_strobe) begin
                lo_cnt <= '0;
                if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
            end
            if ($fell(lcd_strobe)) fall_seen <= 1'b1;
        end
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_strobe) |-> (hi_cnt == PUL_L));

    assert_gap_width_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(lcd_strobe) && fall_seen) |-> (lo_cnt >= GAP_L));

    assert_settle_width_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> (lo_cnt >= SET_L));

    assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (in_ready && $past(in_ready)) |-> !lcd_strobe);
endmodule

// File: tb/sim_charlcd_nibble_writer.sv
`timescale 1ns/1ps
module sim_charlcd_nibble_writer;
    localparam int SETUP  = 2;
    localparam int PULSE  = 12;
    localparam int HOLD   = 1;
    localparam int GAP    = 50;
    localparam int SETTLE = 2000;
    localparam int PERIOD = 2*SETUP + 2*PULSE + 2*HOLD + GAP + SETTLE + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic in_regsel = 1'b0;
    logic lcd_strobe, lcd_regsel, lcd_rdwr;
    logic [3:0] lcd_nib;

    always #2 clk = ~clk;

    charlcd_nibble_writer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_regsel(in_regsel), .lcd_strobe(lcd_strobe),
        .lcd_regsel(lcd_regsel), .lcd_rdwr(lcd_rdwr), .lcd_nib(lcd_nib)
    );

    typedef struct { logic [7:0] d; logic rs; } exp_t;
    exp_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---- monitor / scoreboard ----
    logic pe = 1'b0, prs = 1'b0, cap_rs = 1'b0, up_rs = 1'b0;
    logic [3:0] pnib = '0, cap_nib = '0, up_nib = '0;
    int stab = 0, hi = 0, lo = 0;
    bit fall_seen = 0, half = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (lcd_nib != pnib || lcd_regsel != prs) stab = 0;
            else stab++;
            if (lcd_strobe && !pe) begin
                check(stab >= SETUP, "R6", "setup cycles", stab, SETUP);
                check(lcd_rdwr == 1'b0, "R3", "rdwr level", lcd_rdwr, 0);
                if (fall_seen) begin
                    if (half) check(lo >= GAP, "R9", "nibble gap", lo, GAP);
                    else      check(lo >= SETTLE, "R10", "byte gap", lo, SETTLE);
                end
                cap_nib = lcd_nib;
                cap_rs  = lcd_regsel;
                hi = 0;
            end
            if (lcd_strobe) hi++;
            if (!lcd_strobe && pe) begin
                check(hi == PULSE, "R7", "pulse cycles", hi, PULSE);
                check(lcd_nib == cap_nib && lcd_regsel == cap_rs, "R8", "hold lines",
                      {lcd_regsel, lcd_nib}, {cap_rs, cap_nib});
                fall_seen = 1;
                lo = 1;
                if (!half) begin
                    up_nib = cap_nib;
                    up_rs  = cap_rs;
                    half   = 1;
                end else begin
                    half = 0;
                    if (exp_q.size() == 0) begin
                        check(0, "R11", "unexpected byte", {up_nib, cap_nib}, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check({up_nib, cap_nib} == e.d, "R4", "byte value",
                              {up_nib, cap_nib}, e.d);
                        check(up_rs == e.rs && cap_rs == e.rs, "R5", "regsel",
                              {up_rs, cap_rs}, {e.rs, e.rs});
                    end
                end
            end else if (!lcd_strobe) begin
                lo++;
            end
            pe   = lcd_strobe;
            pnib = lcd_nib;
            prs  = lcd_regsel;
        end
    end

    // ---- driver ----
    task automatic send(logic [7:0] b, logic rs);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = b;
        in_regsel = rs;
        while (!in_ready) @(negedge clk);
        exp_q.push_back('{d: b, rs: rs});
        @(negedge clk);
        check(!in_ready, "R2", "ready after accept", in_ready, 0);
        in_valid = 1'b0;
    endtask

    int last_acc = -1;
    task automatic stream(logic [7:0] b, logic rs);
        in_valid  = 1'b1;
        in_data   = b;
        in_regsel = rs;
        while (!in_ready) @(negedge clk);
        exp_q.push_back('{d: b, rs: rs});
        if (last_acc >= 0)
            check(cyc - last_acc == PERIOD, "R12", "accept period", cyc - last_acc, PERIOD);
        last_acc = cyc;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lcd_strobe == 0, "R1", "reset strobe", lcd_strobe, 0);
        check(lcd_regsel == 0, "R1", "reset regsel", lcd_regsel, 0);
        check(lcd_nib == 0, "R1", "reset nib", lcd_nib, 0);
        check(in_ready == 1, "R1", "reset ready", in_ready, 1);
        check(lcd_rdwr == 0, "R3", "reset rdwr", lcd_rdwr, 0);
        pnib = lcd_nib;
        prs  = lcd_regsel;
        pe   = lcd_strobe;

        send(8'hA5, 1'b0);
        send(8'h3C, 1'b1);
        send(8'hF0, 1'b1);
        send(8'h0F, 1'b0);

        // R11: stray offers with changing data during the busy window
        send(8'h81, 1'b1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_data   = 8'(i * 37);
            in_regsel = i[0];
            if (i == 150) check(!in_ready, "R11", "busy during stray offers", in_ready, 0);
        end
        in_valid = 1'b0;

        // R12: back-to-back stream with in_valid held high
        stream(8'h00, 1'b0);
        stream(8'hFF, 1'b1);
        stream(8'h5A, 1'b0);
        stream(8'h96, 1'b1);
        in_valid = 1'b0;

        repeat (2 * PERIOD) @(negedge clk);
        check(exp_q.size() == 0, "R4", "bytes outstanding", exp_q.size(), 0);
        check(lcd_strobe == 0 && in_ready == 1, "R10", "idle after settle",
              {lcd_strobe, in_ready}, 1);
        done = 1;
        summary();
        $finish;
    end
endmodule